// File: doc/BRIEF.md
# Field Line Decimator with Start-of-Frame Regeneration

This block sits in a streaming video path that carries complete progressive frames and turns each frame into one interlaced field. It removes every second line. A one-bit field-select input decides which lines survive. In the odd field, lines 1, 3, 5 and so on are kept. In the even field, lines 2, 4, 6 and so on are kept. Line boundaries come from the end-of-line flag (`tlast`), and a new frame is marked by the start-of-frame flag (`tuser`).

Dropped lines are consumed at the input and never reach the output. Kept lines pass through with the downstream ready signal honoured beat by beat. In the even field the line that carries the start-of-frame flag is the one that is removed. The block therefore moves that flag onto the first beat of the first line that survives, so downstream logic still sees exactly one frame start per field.

The datapath has no registers. Kept beats cross the block in the same cycle. The only state is the line parity, the latched field, a line-start flag and a pending start-of-frame flag.

Top module: `fld_line_decim`

## Requirements
- R1: With field select 0 (odd field) latched, input lines 1, 3, 5, ... are forwarded and lines 2, 4, 6, ... are removed.
- R2: With field select 1 (even field) latched, input lines 2, 4, 6, ... are forwarded and lines 1, 3, 5, ... are removed.
- R3: Field select is sampled only on the accepted input beat that carries `s_tuser`=1 and is held for the rest of the frame; changes at other times have no effect on which lines are forwarded.
- R4: The line number becomes 1 on every input beat with `s_tuser`=1, including one that arrives before the previous frame has ended, and advances by one after each accepted beat with `s_tlast`=1 (single-beat lines included).
- R5: Beats of a removed line are accepted with `s_tready`=1 and `m_tvalid`=0, whatever the value of `m_tready`.
- R6: On a kept line, `m_tvalid` equals `s_tvalid`, `s_tready` equals `m_tready`, and `m_tdata` and `m_tlast` equal the input unchanged.
- R7: When the beat carrying `s_tuser` lies in a removed line, `m_tuser`=1 is emitted on the first beat of the first kept line and on no other beat of that frame.
- R8: When the beat carrying `s_tuser` lies in a kept line, `m_tuser`=1 appears on that same beat and on no other beat of the frame.
- R9: After reset, with no start-of-frame seen yet, the stream is treated as line 1 of an odd field, no start-of-frame is pending, and `m_tvalid` is 0 while `s_tvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_sel | input | 1 | Field to build: 0 keeps odd lines, 1 keeps even lines |
| s_tdata | input | DATA_W | Input pixel data |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tlast | input | 1 | Input end of line |
| s_tuser | input | 1 | Input start of frame |
| m_tdata | output | DATA_W | Output pixel data |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Output end of line |
| m_tuser | output | 1 | Output start of frame, regenerated when needed |

## Verification
The bench targets the even field, where the start-of-frame beat is removed. A design that forgot to move the flag would emit a field with no frame start, and one that did not clear the pending flag would mark a second line. Single-beat lines, frames cut short by a new start-of-frame, and a field select that flips right after the frame start are all covered. A design with a free-running or unlatched line parity would keep the wrong lines in those cases. Removed lines are also driven while the output is stalled: a design that tied input ready to output ready there would stall the whole stream.

// File: rtl/fld_decim_pkg.sv
package fld_decim_pkg;

    typedef enum logic {
        FIELD_ODD  = 1'b0,
        FIELD_EVEN = 1'b1
    } field_e;

    // position of the current input line within the frame
    typedef struct packed {
        logic   line_odd;
        field_e field;
    } line_pos_t;

    localparam line_pos_t POS_RESET = '{line_odd: 1'b1, field: FIELD_ODD};

    function automatic logic line_is_kept(input line_pos_t pos);
        return (pos.field == FIELD_ODD) ? pos.line_odd : !pos.line_odd;
    endfunction

endpackage

// File: rtl/fld_line_track.sv
module fld_line_track
    import fld_decim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      beat_acc,
    input  logic      beat_sof,
    input  logic      beat_last,
    input  field_e    field_in,
    output line_pos_t cur_pos,
    output logic      keep
);

    line_pos_t pos_q;

    // a start-of-frame beat is always line 1 of the newly selected field
    always_comb begin
        if (beat_sof) begin
            cur_pos = '{line_odd: 1'b1, field: field_in};
        end else begin
            cur_pos = pos_q;
        end
        keep = line_is_kept(cur_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_RESET;
        end else if (beat_acc) begin
            if (beat_sof) begin
                pos_q <= '{line_odd: !beat_last, field: field_in};
            end else if (beat_last) begin
                pos_q.line_odd <= !pos_q.line_odd;
            end
        end
    end

endmodule

// File: rtl/fld_sof_regen.sv
module fld_sof_regen (
    input  logic clk,
    input  logic rst,
    input  logic beat_acc,
    input  logic beat_sof,
    input  logic beat_last,
    input  logic keep,
    output logic sof_out
);

    logic owed_q;
    logic line_start_q;

    assign sof_out = keep & (beat_sof | (owed_q & line_start_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q       <= 1'b0;
            line_start_q <= 1'b1;
        end else if (beat_acc) begin
            line_start_q <= beat_last;
            if (beat_sof) begin
                owed_q <= !keep;
            end else if (keep) begin
                owed_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fld_line_decim.sv
module fld_line_decim
    import fld_decim_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_sel,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    input  logic              s_tuser,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic              m_tuser
);

    line_pos_t cur_pos;
    logic      keep;
    logic      beat_acc;
    logic      sof_out;

    assign beat_acc = s_tvalid & s_tready;

    fld_line_track u_track (
        .clk       (clk),
        .rst       (rst),
        .beat_acc  (beat_acc),
        .beat_sof  (s_tuser),
        .beat_last (s_tlast),
        .field_in  (field_e'(field_sel)),
        .cur_pos   (cur_pos),
        .keep      (keep)
    );

    fld_sof_regen u_sof (
        .clk       (clk),
        .rst       (rst),
        .beat_acc  (beat_acc),
        .beat_sof  (s_tuser),
        .beat_last (s_tlast),
        .keep      (keep),
        .sof_out   (sof_out)
    );

    // removed lines are swallowed, kept lines follow downstream ready
    assign s_tready = keep ? m_tready : 1'b1;
    assign m_tvalid = s_tvalid & keep;
    assign m_tdata  = s_tdata;
    assign m_tlast  = s_tlast;
    assign m_tuser  = sof_out;

endmodule

// File: rtl/fld_line_decim_chk.sv
module fld_line_decim_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] s_tdata,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              s_tlast,
    input logic              s_tuser,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic              m_tlast,
    input logic              m_tuser
);

    logic out_line_start_q;
    logic sof_sent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_line_start_q <= 1'b1;
            sof_sent_q       <= 1'b0;
        end else begin
            if (m_tvalid && m_tready) begin
                out_line_start_q <= m_tlast;
            end
            if (s_tvalid && s_tready && s_tuser) begin
                sof_sent_q <= m_tvalid && m_tuser;
            end else if (m_tvalid && m_tready && m_tuser) begin
                sof_sent_q <= 1'b1;
            end
        end
    end

    // R6
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (s_tvalid && m_tdata == s_tdata && m_tlast == s_tlast));

    // R6
    ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (s_tready == m_tready));

    // R5
    drop_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && !m_tvalid) |-> s_tready);

    // R7
    single_sof_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tuser && !s_tuser) |-> !sof_sent_q);

    // R7
    sof_at_line_start_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tuser) |-> out_line_start_q);

    // R8
    sof_kept_in_place_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && s_tuser) |-> m_tuser);

endmodule

bind fld_line_decim fld_line_decim_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_tdata  (s_tdata),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tlast  (s_tlast),
    .s_tuser  (s_tuser),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .m_tuser  (m_tuser)
);

// File: tb/tb_fld_line_decim.sv
`timescale 1ns/1ps
module tb_fld_line_decim;

    localparam int DATA_W = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              field_sel = 1'b0;
    logic [DATA_W-1:0] s_tdata = '0;
    logic              s_tvalid = 1'b0;
    logic              s_tready;
    logic              s_tlast = 1'b0;
    logic              s_tuser = 1'b0;
    logic [DATA_W-1:0] m_tdata;
    logic              m_tvalid;
    logic              m_tready;
    logic              m_tlast;
    logic              m_tuser;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int bp_mode  = 0;
    int pt_err   = 0;
    int drop_err = 0;

    logic [DATA_W+1:0] exp_q[$];
    logic [DATA_W+1:0] got_q[$];

    always #10 clk = ~clk;   // 50 MHz

    fld_line_decim #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .field_sel(field_sel),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_tuser(s_tuser),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .m_tuser(m_tuser)
    );

    // downstream ready pattern
    initial m_tready = 1'b1;
    always @(posedge clk) begin
        #1;
        cyc <= cyc + 1;
        case (bp_mode)
            0:       m_tready = 1'b1;
            1:       m_tready = (cyc % 3) != 0;
            default: m_tready = 1'b0;
        endcase
    end

    // output monitor and per-cycle port relations
    always @(negedge clk) begin
        if (!rst) begin
            if (m_tvalid && m_tready) got_q.push_back({m_tuser, m_tlast, m_tdata});
            if (m_tvalid && (!s_tvalid || s_tready !== m_tready ||
                             m_tdata !== s_tdata || m_tlast !== s_tlast)) pt_err++;
            if (s_tvalid && !m_tvalid && !s_tready) drop_err++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pix(input int fid, input int l, input int b);
        return {fid[7:0], l[7:0], b[7:0]};
    endfunction

    task automatic send_beat(input logic [DATA_W-1:0] d, input logic u, input logic l,
                             output int waits);
        bit acc;
        s_tvalid = 1'b1; s_tdata = d; s_tuser = u; s_tlast = l;
        waits = 0;
        forever begin
            @(negedge clk);
            acc = s_tready;
            waits++;
            @(posedge clk); #1;
            if (acc) break;
        end
        s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
    endtask

    // field f latched on the SOF beat; field_sel flips for all later beats (R3)
    task automatic send_frame(input int fid, input int nl, input int wpl,
                              input bit f, input bit has_sof, input bit gap);
        int w;
        for (int l = 1; l <= nl; l++) begin
            for (int b = 0; b < wpl; b++) begin
                field_sel = (l == 1 && b == 0) ? f : ~f;
                if (gap && (b % 2 == 1)) begin
                    @(posedge clk); #1;
                end
                send_beat(pix(fid, l, b), has_sof && l == 1 && b == 0, b == wpl - 1, w);
            end
        end
    endtask

    task automatic build_expected(input int fid, input int nl, input int wpl,
                                  input bit f, input bit has_sof);
        bit first = 1'b1;
        bit fe = has_sof ? f : 1'b0;
        for (int l = 1; l <= nl; l++) begin
            if ((fe == 1'b0) ? (l % 2 == 1) : (l % 2 == 0)) begin
                for (int b = 0; b < wpl; b++) begin
                    exp_q.push_back({has_sof && first, b == wpl - 1, pix(fid, l, b)});
                    first = 1'b0;
                end
            end
        end
    endtask

    task automatic compare(input string req);
        repeat (2) @(posedge clk);
        #1;
        check(got_q.size() == exp_q.size(), req, "beat count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] === exp_q[i], req, $sformatf("beat %0d {user,last,data}", i),
                  got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic frame(input int fid, input int nl, input int wpl, input bit f,
                         input bit has_sof, input bit gap, input string req);
        build_expected(fid, nl, wpl, f, has_sof);
        send_frame(fid, nl, wpl, f, has_sof, gap);
        compare(req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R9", "m_tvalid after reset", m_tvalid, 0);
        check(m_tuser == 1'b0, "R9", "m_tuser after reset", m_tuser, 0);
        @(posedge clk); #1;
    endtask

    // no SOF yet: odd field from line 1 although field_sel says even (R9)
    task automatic t_no_sof;
        frame(1, 4, 3, 1'b1, 1'b0, 1'b0, "R9");
        // line count stands at 5 now; the next SOF must restart it (R4)
    endtask

    task automatic t_odd;
        frame(2, 6, 4, 1'b0, 1'b1, 1'b0, "R1/R8");
        frame(3, 5, 2, 1'b0, 1'b1, 1'b1, "R1");
    endtask

    task automatic t_even;
        frame(4, 6, 4, 1'b1, 1'b1, 1'b0, "R2/R7");
        frame(5, 7, 3, 1'b1, 1'b1, 1'b1, "R2/R7");
    endtask

    task automatic t_field_flip;
        // field_sel toggles after every SOF beat inside send_frame
        frame(6, 4, 2, 1'b1, 1'b1, 1'b0, "R3");
        frame(7, 4, 2, 1'b0, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_restart;
        // frame cut after 3 lines, next SOF restarts counting (R4)
        frame(8, 3, 2, 1'b1, 1'b1, 1'b0, "R4");
        frame(9, 1, 4, 1'b1, 1'b1, 1'b0, "R4");   // only line 1, pending SOF abandoned
        frame(10, 4, 3, 1'b0, 1'b1, 1'b0, "R4");
        // single-beat lines
        frame(11, 5, 1, 1'b1, 1'b1, 1'b0, "R4/R7");
        frame(12, 5, 1, 1'b0, 1'b1, 1'b0, "R4/R8");
    endtask

    task automatic t_backpressure;
        pt_err = 0;
        bp_mode = 1;
        frame(13, 6, 5, 1'b1, 1'b1, 1'b1, "R6");
        frame(14, 6, 5, 1'b0, 1'b1, 1'b0, "R6");
        bp_mode = 0;
        check(pt_err == 0, "R6", "passthrough mismatches", pt_err, 0);
    endtask

    // removed line must drain while downstream is stalled (R5)
    task automatic t_drop_stall;
        int w;
        int worst = 0;
        drop_err = 0;
        bp_mode = 2;
        @(posedge clk); #1;
        for (int b = 0; b < 4; b++) begin
            field_sel = (b == 0) ? 1'b1 : 1'b0;
            send_beat(pix(15, 1, b), b == 0, b == 3, w);
            if (w > worst) worst = w;
        end
        check(worst == 1, "R5", "cycles per removed beat under stall", worst, 1);
        check(got_q.size() == 0, "R5", "beats forwarded from removed line", got_q.size(), 0);
        check(drop_err == 0, "R5", "removed beat not accepted", drop_err, 0);
        bp_mode = 0;
        @(posedge clk); #1;
        for (int b = 0; b < 4; b++)
            exp_q.push_back({b == 0, b == 3, pix(15, 2, b)});
        for (int b = 0; b < 4; b++)
            send_beat(pix(15, 2, b), 1'b0, b == 3, w);
        compare("R5/R7");
    endtask

    initial begin
        t_reset();
        t_no_sof();
        t_odd();
        t_even();
        t_field_flip();
        t_restart();
        t_backpressure();
        t_drop_stall();
        check(drop_err == 0 && pt_err == 0, "R5/R6", "port relation errors",
              drop_err + pt_err, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule